// File: doc/BRIEF.md
# Port-Programmed 16 KB Bank Mapper

This block turns a 16-bit CPU address into a 19-bit physical address for a 512 KB RAM. The RAM is split into thirty-two 16 KB banks. The CPU address space has four 16 KB windows, selected by address bits 15:14. A 5-bit configuration number decides which physical bank sits behind each window. Software loads that number with an I/O write whose data byte has its two top bits set.

The first eight configurations follow a fixed legacy arrangement. Configurations 8 to 31 place bank n in the second window and force bank 7 into the top window. The RAM is built as two DRAM groups. Banks 0–15 are in the low group. Banks 16–31 are in the high group, and only CPU accesses through the second window can reach them.

Video-fetch accesses mostly see the window number as the bank. In the second window they take bank bits 1:0 from the configuration. A reduced-capacity input selects a 320 KB build, in which only banks 0 to 19 exist.

Top module: `bank_window_mapper`

## Requirements
- R1: On a rising clock edge where `io_wr`=1, `cpu_addr[15]`=0 and `io_data[7:6]`=2'b11, the configuration register takes `io_data[4:0]`. No other I/O write changes it, and this includes data bytes 00h–BFh and writes with `cpu_addr[15]`=1. The new value drives the outputs from the next cycle on.
- R2: Reset (`rst_n`=0) clears the configuration to 0. CPU accesses then map windows 0,1,2,3 to banks 0,1,2,3.
- R3: For CPU accesses, the banks for windows 0,1,2,3 are:
  - configuration 0: 0,1,2,3
  - configuration 1: 0,1,2,7
  - configuration 2: 4,5,6,7
  - configuration 3: 0,3,2,7
- R4: For CPU accesses under configurations 4–7, windows 0,1,2,3 map to banks 0, c, 2, 3, where c is the configuration number.
- R5: For CPU accesses under configurations 8–31, windows 0,1,2,3 map to banks 0, c, 2, 7.
- R6: `grp_hi_en`=1 exactly when three things hold: `cpu_access`=1, window is 1 (4000h–7FFFh), and configuration bit 4 is 1 (subject to R7). In every other case `grp_lo_en`=1. The two enables are never high together.
- R7: With `reduced_cap`=1, a CPU access in window 1 under configurations 20–31 drives both enables low. Configurations 16–19 still assert `grp_hi_en`.
- R8: For video-fetch accesses (`cpu_access`=0), window 1 uses bank {3'b000, configuration[1:0]}, and every other window uses its own window number as the bank. `grp_hi_en` stays 0.
- R9: `phys_bank` is the bank, `phys_offset` equals `cpu_addr[13:0]`, and `phys_addr` equals {`phys_bank`, `cpu_addr[13:0]`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address; bit 15 also qualifies I/O writes |
| cpu_access | input | 1 | 1 = CPU access, 0 = video fetch |
| io_wr | input | 1 | I/O write strobe |
| io_data | input | 8 | I/O write data byte |
| reduced_cap | input | 1 | 1 = 320 KB build (banks 0–19 only) |
| phys_bank | output | 5 | Physical bank number |
| phys_offset | output | 14 | Offset within the bank |
| phys_addr | output | 19 | Physical byte address |
| grp_lo_en | output | 1 | Enable for DRAM group of banks 0–15 |
| grp_hi_en | output | 1 | Enable for DRAM group of banks 16–31 |

## Verification
A configuration write and a translation can fall in the same cycle. The bench provokes this by holding a CPU address in window 1 while it pulses an accepted write. It judges the result by checking that the bank still reflects the old configuration before the edge and the new one after it. The second overlap is a video fetch in window 1 while a high configuration is active. In that case the low configuration bits must reach `phys_bank` while `grp_hi_en` stays low. The bench covers this by sweeping every configuration against all four windows, both access types and both capacity modes.

// File: rtl/bank_window_mapper.sv
module bank_window_mapper #(
  parameter int BANK_W   = 5,
  parameter int OFS_W    = 14,
  parameter int RED_LAST = 19
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [15:0]            cpu_addr,
  input  logic                   cpu_access,
  input  logic                   io_wr,
  input  logic [7:0]             io_data,
  input  logic                   reduced_cap,
  output logic [BANK_W-1:0]      phys_bank,
  output logic [OFS_W-1:0]       phys_offset,
  output logic [BANK_W+OFS_W-1:0] phys_addr,
  output logic                   grp_lo_en,
  output logic                   grp_hi_en
);
  logic [BANK_W-1:0] cfg_q;
  logic [BANK_W-1:0] cpu_bank;
  logic [BANK_W-1:0] vid_bank;
  logic [1:0]        win;
  logic              cfg_load, hi_sel, void_sel;

  assign win      = cpu_addr[15:14];
  assign cfg_load = io_wr && !cpu_addr[15] && (io_data[7:6] == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n)        cfg_q <= '0;
    else if (cfg_load) cfg_q <= io_data[BANK_W-1:0];
  end

  always_comb begin
    case (win)
      2'd0: cpu_bank = (cfg_q == 5'd2) ? 5'd4 : 5'd0;
      2'd1: begin
        if (cfg_q < 5'd2)       cpu_bank = 5'd1;
        else if (cfg_q == 5'd2) cpu_bank = 5'd5;
        else                    cpu_bank = cfg_q;
      end
      2'd2: cpu_bank = (cfg_q == 5'd2) ? 5'd6 : 5'd2;
      default: cpu_bank = (cfg_q == 5'd0 || (cfg_q >= 5'd4 && cfg_q <= 5'd7)) ? 5'd3 : 5'd7;
    endcase
  end

  assign vid_bank  = (win == 2'd1) ? {3'b000, cfg_q[1:0]} : {3'b000, win};
  assign phys_bank = cpu_access ? cpu_bank : vid_bank;

  assign hi_sel    = cpu_access && (win == 2'd1) && cfg_q[BANK_W-1];
  assign void_sel  = hi_sel && reduced_cap && (cfg_q > RED_LAST[BANK_W-1:0]);
  assign grp_hi_en = hi_sel && !void_sel;
  assign grp_lo_en = !hi_sel;

  assign phys_offset = cpu_addr[OFS_W-1:0];
  assign phys_addr   = {phys_bank, phys_offset};
endmodule

// File: rtl/bank_window_mapper_chk.sv
module bank_window_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_access,
  input logic        io_wr,
  input logic [7:0]  io_data,
  input logic [4:0]  cfg_q,
  input logic [4:0]  phys_bank,
  input logic        grp_lo_en,
  input logic        grp_hi_en
);
  a_r1_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && !cpu_addr[15] && io_data[7:6] == 2'b11) |=> $stable(cfg_q));

  a_r1_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !cpu_addr[15] && io_data[7:6] == 2'b11) |=> cfg_q == $past(io_data[4:0]));

  a_r6_hi_only_cpu_win1: assert property (@(posedge clk) disable iff (!rst_n)
    grp_hi_en |-> (cpu_access && cpu_addr[15:14] == 2'd1 && phys_bank[4]));

  a_r6_groups_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(grp_lo_en && grp_hi_en));

  a_r8_video_low_banks: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_access |-> (phys_bank[4:2] == 3'b000 && !grp_hi_en));
endmodule

bind bank_window_mapper bank_window_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_access(cpu_access),
  .io_wr(io_wr), .io_data(io_data), .cfg_q(cfg_q), .phys_bank(phys_bank),
  .grp_lo_en(grp_lo_en), .grp_hi_en(grp_hi_en)
);

// File: tb/bank_window_mapper_test.sv
module bank_window_mapper_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic        cpu_access = 1;
  logic        io_wr = 0;
  logic [7:0]  io_data = 0;
  logic        reduced_cap = 0;
  logic [4:0]  phys_bank;
  logic [13:0] phys_offset;
  logic [18:0] phys_addr;
  logic        grp_lo_en, grp_hi_en;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bank_window_mapper uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_access(cpu_access),
    .io_wr(io_wr), .io_data(io_data), .reduced_cap(reduced_cap),
    .phys_bank(phys_bank), .phys_offset(phys_offset), .phys_addr(phys_addr),
    .grp_lo_en(grp_lo_en), .grp_hi_en(grp_hi_en)
  );

  function automatic int exp_bank(int c, int w, bit cpu);
    int tbl [4][4] = '{'{0,1,2,3}, '{0,1,2,7}, '{4,5,6,7}, '{0,3,2,7}};
    if (!cpu) return (w == 1) ? (c % 4) : w;
    if (c < 4) return tbl[c][w];
    case (w)
      0: return 0;
      1: return c;
      2: return 2;
      default: return (c < 8) ? 3 : 7;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_io(logic a15, logic [7:0] d);
    @(negedge clk);
    cpu_addr[15] = a15; io_data = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0; cpu_addr = 16'h0000;
  endtask

  task automatic probe_win1(string req, int exp);
    cpu_access = 1; cpu_addr = 16'h4000; #1;
    check(req, phys_bank, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int w = 0; w < 4; w++) begin
      cpu_addr = 16'(w << 14); #1;
      check("R2 reset map", phys_bank, w);
    end

    write_io(0, 8'hC5); probe_win1("R1 load C5", 5);
    write_io(0, 8'hBF); probe_win1("R1 reject BF", 5);
    write_io(0, 8'h7F); probe_win1("R1 reject 7F", 5);
    write_io(0, 8'h00); probe_win1("R1 reject 00", 5);
    write_io(1, 8'hC6); probe_win1("R1 reject a15", 5);
    write_io(0, 8'hE3); probe_win1("R1 low five bits", 3);

    @(negedge clk);
    cpu_addr = 16'h4000; io_data = 8'hCC; io_wr = 1; #1;
    check("R1 old cfg before edge", phys_bank, 3);
    @(negedge clk); io_wr = 0; #1;
    check("R1 new cfg after edge", phys_bank, 12);

    for (int c = 0; c < 32; c++) begin
      write_io(0, 8'hC0 | 8'(c));
      for (int r = 0; r < 2; r++) begin
        reduced_cap = r[0];
        for (int cp = 0; cp < 2; cp++) begin
          for (int w = 0; w < 4; w++) begin
            int eb; bit ehi, elo;
            cpu_access = cp[0];
            cpu_addr = 16'((w << 14) | ((c * 613 + w * 97) & 16'h3FFF)); #1;
            eb  = exp_bank(c, w, cp[0]);
            ehi = cp[0] && w == 1 && c >= 16 && !(r == 1 && c >= 20);
            elo = !(cp[0] && w == 1 && c >= 16);
            if (!cp[0])      check("R8 video bank", phys_bank, eb);
            else if (c < 4)  check("R3 legacy map", phys_bank, eb);
            else if (c < 8)  check("R4 cfg4-7 map", phys_bank, eb);
            else             check("R5 cfg8-31 map", phys_bank, eb);
            if (r == 1 && c >= 20 && cp[0] && w == 1)
              check("R7 reduced void", {grp_hi_en, grp_lo_en}, 0);
            else
              check("R6 group enables", {grp_hi_en, grp_lo_en}, {ehi, elo});
            check("R9 offset", phys_offset, cpu_addr[13:0]);
            check("R9 phys addr", phys_addr, (eb << 14) | cpu_addr[13:0]);
          end
        end
      end
    end
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule